// File: doc/BRIEF.md
# Real-Time Clock with Selectable Tap Interrupt

This block keeps time of day. It counts pulses of a slow reference tick (one system-clock-wide enable pulse per slow oscillator period) through a reloadable down-counting prescaler. The prescaler produces one tick per second, and that tick drives a cascade of second, minute and hour counters. A five-bit select code routes any single bit of those three counters to the output `rtc_out`. Each falling edge of the selected bit raises a one-cycle interrupt pulse and sets a sticky wake request. Software clears that request by writing a one to the status register. A bypass control feeds every slow tick straight into the second counter, which makes test runs short.

Registers are reached through a synchronous port. Writes take effect on the clock edge where `wr_en` is high. `rdata` is registered and shows the register addressed at the previous edge. Loading the time, changing the select code or changing the prescaler state can move the selected bit. When that move is a fall, it raises an interrupt just as a counting step would.

The wake logic is a two-state machine. In `WK_CLEAR` no request is pending, and a qualified falling edge takes it to `WK_PENDING`. In `WK_PENDING` the wake request is high. A status clear with no falling edge in the same cycle returns it to `WK_CLEAR`. A falling edge in that cycle keeps it in `WK_PENDING` and pulses the interrupt again.

Top module: `rtc_tap_irq`

## Requirements
- R1: After reset, the time, select code, bypass, reload value and prescaler count are all zero, and `wake_o`, `irq_o` and `rtc_out` are low.
- R2: With bypass off, a slow tick that finds the prescaler at zero advances the seconds and reloads the prescaler. Any other slow tick decrements the prescaler. So after the first second, the seconds advance once every reload+1 ticks.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next counter. Hours wrap from 23 to 0.
- R4: A write to address 2 loads seconds from bits [5:0], minutes from [11:6] and hours from [17:12] on the same edge, and restarts the prescaler at the reload value. A field above its maximum (59, 59, 23) loads as zero.
- R5: The select code sits in bits [4:0] of address 0. Codes 1–6 route second bits 0–5, codes 7–12 route minute bits 0–5, and codes 13–17 route hour bits 0–4 to `rtc_out`. Every other code drives `rtc_out` low.
- R6: A 1-to-0 change of the selected bit, under a valid code (1–17), drives `irq_o` high for exactly one cycle, on the clock edge after the change.
- R7: The same edge that raises `irq_o` sets the status flag (bit 0 of address 3). `wake_o` follows this flag and holds until it is cleared.
- R8: Writing address 3 with bit 0 set clears the flag. Writing it with bit 0 clear has no effect. A falling edge in the same cycle as a clear wins.
- R9: Under code 0 or codes 18–31 no interrupt and no wake request occur, even when the code change itself drops the output.
- R10: Bypass (bit 5 of address 0) makes every slow tick advance the seconds and freezes the prescaler.
- R11: Reads return the control (select, bypass), reload, time and status words in the same bit positions one cycle after the address is presented. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow reference period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 reload, 2 time, 3 status) |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Registered read data |
| rtc_out | output | 1 | Selected counter bit |
| irq_o | output | 1 | One-cycle interrupt pulse on a falling edge of `rtc_out` |
| wake_o | output | 1 | Sticky wake request |

## Verification
The bench builds the block with a four-bit prescaler, so reload values run only up to 15. This brings full prescaler periods, reloads that land mid-count and many second carries within a few hundred ticks. A directed load of 23:59:59 followed by a bypassed tick reaches the triple rollover. Hour taps and minute carries are reached by loading times near the wrap points rather than by counting for hours. Random runs mix ticks, time loads, select changes (including invalid codes) and status clears. Together they bring out the spurious edges that writes cause, as well as those that counting causes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int SEL_W     = 5;
    localparam int UNIT_W    = 6;
    localparam int N_UNITS   = 3;
    localparam int SEC_MAX   = 59;
    localparam int MIN_MAX   = 59;
    localparam int HR_MAX    = 23;
    localparam int TAP_LAST  = 17;
    localparam int REG_W     = N_UNITS * UNIT_W;
    localparam int BYP_BIT   = SEL_W;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_TIME   = 2'd2;
    localparam logic [1:0] A_STAT   = 2'd3;

    typedef enum logic [0:0] {
        WK_CLEAR   = 1'b0,
        WK_PENDING = 1'b1
    } wake_state_e;

    function automatic int unit_max(input int idx);
        return (idx == 0) ? SEC_MAX : (idx == 1) ? MIN_MAX : HR_MAX;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             bypass,
    input  logic             restart,
    input  logic [PRE_W-1:0] reload,
    output logic             sec_tick
);
    logic [PRE_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero  = (cnt_q == '0);
    assign sec_tick = tick && (bypass || at_zero);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= reload;
        end else if (tick && !bypass) begin
            cnt_q <= at_zero ? reload : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
    parameter int W   = 6,
    parameter int MAX = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    logic [W-1:0] cnt_q;
    logic         at_limit;

    assign at_limit = (cnt_q == LIMIT);
    assign carry    = inc && at_limit && !load;
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val <= LIMIT) ? load_val : '0;
        end else if (inc) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sec_tick,
    input  logic                            load,
    input  logic [N_UNITS-1:0][UNIT_W-1:0]  load_val,
    output logic [N_UNITS-1:0][UNIT_W-1:0]  value
);
    logic [N_UNITS-1:0] carry;
    logic [N_UNITS-1:0] inc;

    genvar g;
    generate
        for (g = 0; g < N_UNITS; g++) begin : g_unit
            if (g == 0) begin : g_first
                assign inc[g] = sec_tick;
            end else begin : g_next
                assign inc[g] = carry[g-1];
            end
            rtc_wrap_counter #(
                .W   (UNIT_W),
                .MAX (unit_max(g))
            ) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .load_val (load_val[g]),
                .inc      (inc[g]),
                .cnt      (value[g]),
                .carry    (carry[g])
            );
        end
    endgenerate
endmodule

// File: rtl/rtc_tap_mux.sv
module rtc_tap_mux
    import rtc_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [UNIT_W-1:0] sc,
    input  logic [UNIT_W-1:0] mn,
    input  logic [UNIT_W-1:0] hr,
    output logic              tap,
    output logic              sel_ok
);
    localparam int TAP_N = 1 << SEL_W;
    localparam int PAD_W = TAP_N - 1 - N_UNITS * UNIT_W;

    logic [TAP_N-1:0] taps;

    // Bit 0 is the idle code. Bit 18 is the hour MSB, which never reaches 1.
    assign taps   = {{PAD_W{1'b0}}, hr, mn, sc, 1'b0};
    assign tap    = taps[sel];
    assign sel_ok = (sel != '0) && (sel <= SEL_W'(TAP_LAST));
endmodule

// File: rtl/rtc_wake_fsm.sv
module rtc_wake_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    input  logic sel_ok,
    input  logic clr,
    output logic fall,
    output logic irq,
    output logic wake
);
    wake_state_e state_q, state_d;
    logic        tap_q;
    logic        irq_q;

    assign fall = tap_q && !tap && sel_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q   <= 1'b0;
            state_q <= WK_CLEAR;
        end else begin
            tap_q   <= tap;
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_CLEAR:   state_d = fall ? WK_PENDING : WK_CLEAR;
            WK_PENDING: state_d = (clr && !fall) ? WK_CLEAR : WK_PENDING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= fall;
        end
    end

    assign irq  = irq_q;
    assign wake = (state_q == WK_PENDING);
endmodule

// File: rtl/rtc_tap_irq.sv
module rtc_tap_irq
    import rtc_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             rtc_out,
    output logic             irq_o,
    output logic             wake_o
);
    logic [SEL_W-1:0]                 sel_q;
    logic                             byp_q;
    logic [PRE_W-1:0]                 reload_q;
    logic [REG_W-1:0]                 rdata_q;
    logic                             time_load;
    logic                             stat_clr;
    logic                             sec_tick;
    logic                             sel_ok;
    logic                             edge_fall;
    logic [N_UNITS-1:0][UNIT_W-1:0]   load_val;
    logic [N_UNITS-1:0][UNIT_W-1:0]   tval;
    logic [UNIT_W-1:0]                cur_sc, cur_mn, cur_hr;

    assign time_load = wr_en && (addr == A_TIME);
    assign stat_clr  = wr_en && (addr == A_STAT) && wdata[0];
    assign load_val  = wdata;
    assign cur_sc    = tval[0];
    assign cur_mn    = tval[1];
    assign cur_hr    = tval[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            byp_q    <= 1'b0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) begin
                sel_q <= wdata[SEL_W-1:0];
                byp_q <= wdata[BYP_BIT];
            end
            if (addr == A_RELOAD) begin
                reload_q <= wdata[PRE_W-1:0];
            end
        end
    end

    rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (slow_tick),
        .bypass   (byp_q),
        .restart  (time_load),
        .reload   (reload_q),
        .sec_tick (sec_tick)
    );

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .load     (time_load),
        .load_val (load_val),
        .value    (tval)
    );

    rtc_tap_mux u_mux (
        .sel    (sel_q),
        .sc     (cur_sc),
        .mn     (cur_mn),
        .hr     (cur_hr),
        .tap    (rtc_out),
        .sel_ok (sel_ok)
    );

    rtc_wake_fsm u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap    (rtc_out),
        .sel_ok (sel_ok),
        .clr    (stat_clr),
        .fall   (edge_fall),
        .irq    (irq_o),
        .wake   (wake_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (addr)
                A_CTRL:   rdata_q <= REG_W'({byp_q, sel_q});
                A_RELOAD: rdata_q <= REG_W'(reload_q);
                A_TIME:   rdata_q <= tval;
                A_STAT:   rdata_q <= REG_W'(wake_o);
            endcase
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/rtc_tap_irq_chk.sv
module rtc_tap_irq_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq_o,
    input logic              wake_o,
    input logic [SEL_W-1:0]  sel_q,
    input logic              fall,
    input logic              clr,
    input logic              time_load,
    input logic [REG_W-1:0]  wdata,
    input logic [UNIT_W-1:0] sc,
    input logic [UNIT_W-1:0] mn,
    input logic [UNIT_W-1:0] hr
);
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_irq_sets_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    assert_wake_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !clr) |=> wake_o);

    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fall) |=> !wake_o);

    assert_idle_code_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sel_q) == '0) || ($past(sel_q) > SEL_W'(TAP_LAST))) |-> !irq_o);

    assert_time_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc <= UNIT_W'(SEC_MAX)) && (mn <= UNIT_W'(MIN_MAX)) && (hr <= UNIT_W'(HR_MAX)));

    assert_load_seconds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (time_load && (wdata[UNIT_W-1:0] <= UNIT_W'(SEC_MAX)))
            |=> (sc == $past(wdata[UNIT_W-1:0])));
endmodule

bind rtc_tap_irq rtc_tap_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .sel_q     (sel_q),
    .fall      (edge_fall),
    .clr       (stat_clr),
    .time_load (time_load),
    .wdata     (wdata),
    .sc        (cur_sc),
    .mn        (cur_mn),
    .hr        (cur_hr)
);

// File: tb/sim_rtc_tap_irq.sv
module sim_rtc_tap_irq;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        rtc_out, irq_o, wake_o;

    int n_chk = 0, n_err = 0, irq_seen = 0, exp_irq = 0;
    int m_sc = 0, m_mn = 0, m_hr = 0, m_pre = 0, m_rel = 0, m_sel = 0, m_byp = 0, m_flag = 0;
    bit done = 0;

    rtc_tap_irq #(.PRE_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rtc_out(rtc_out),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (rst_n && irq_o) irq_seen++;

    function automatic int tap_of(int sel, int sc, int mn, int hr);
        if (sel >= 1 && sel <= 6)   return (sc >> (sel - 1)) & 1;
        if (sel >= 7 && sel <= 12)  return (mn >> (sel - 7)) & 1;
        if (sel >= 13 && sel <= 17) return (hr >> (sel - 13)) & 1;
        return 0;
    endfunction

    function automatic int time_word(int sc, int mn, int hr);
        return (hr << 12) | (mn << 6) | sc;
    endfunction

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic note_edge(int t0);
        int t1 = tap_of(m_sel, m_sc, m_mn, m_hr);
        if (t0 == 1 && t1 == 0 && m_sel >= 1 && m_sel <= 17) begin
            exp_irq++;
            m_flag = 1;
        end
    endtask

    task automatic step_sec();
        m_sc++;
        if (m_sc > 59) begin
            m_sc = 0; m_mn++;
            if (m_mn > 59) begin
                m_mn = 0; m_hr++;
                if (m_hr > 23) m_hr = 0;
            end
        end
    endtask

    task automatic do_write(int a, int d);
        int t0 = tap_of(m_sel, m_sc, m_mn, m_hr);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'(a); wdata = 18'(d);
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            0: begin m_sel = d & 31; m_byp = (d >> 5) & 1; end
            1: m_rel = d & ((1 << PW) - 1);
            2: begin
                m_sc = d & 63; m_mn = (d >> 6) & 63; m_hr = (d >> 12) & 63;
                if (m_sc > 59) m_sc = 0;
                if (m_mn > 59) m_mn = 0;
                if (m_hr > 23) m_hr = 0;
                m_pre = m_rel;
            end
            default: if (d & 1) m_flag = 0;
        endcase
        note_edge(t0);
        @(negedge clk);
    endtask

    task automatic do_tick();
        int t0 = tap_of(m_sel, m_sc, m_mn, m_hr);
        @(negedge clk);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        if (m_byp != 0) step_sec();
        else if (m_pre == 0) begin m_pre = m_rel; step_sec(); end
        else m_pre--;
        note_edge(t0);
        @(negedge clk);
    endtask

    task automatic do_read(int a, output int v);
        @(negedge clk);
        addr = 2'(a);
        @(negedge clk);
        v = int'(rdata);
    endtask

    task automatic check_state(string req);
        int v;
        do_read(2, v);
        check({req, " time"}, v, time_word(m_sc, m_mn, m_hr));
        check({req, " irq count"}, irq_seen, exp_irq);
        check({req, " wake"}, int'(wake_o), m_flag);
        check({req, " rtc_out"}, int'(rtc_out), tap_of(m_sel, m_sc, m_mn, m_hr));
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (8 * 150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset state through the read port
        check("R1 irq", int'(irq_o), 0);
        check("R1 wake", int'(wake_o), 0);
        check("R1 rtc_out", int'(rtc_out), 0);
        for (int a = 0; a < 4; a++) begin
            do_read(a, v);
            check("R1 R11 reset read", v, 0);
        end

        // R2: prescaler period with reload 3, tapping second bit 0
        do_write(1, 3);
        do_write(0, 1);
        for (int i = 0; i < 9; i++) do_tick();
        check_state("R2 R6 prescaled count");
        check("R2 seconds after 9 ticks", m_sc, 3);

        // R5: tap routing at 00:05:03
        do_write(2, time_word(3, 5, 0));
        do_write(0, 2);
        check("R5 second bit1", int'(rtc_out), 1);
        do_write(0, 8);
        check("R5 minute bit1", int'(rtc_out), 0);
        do_write(0, 7);
        check("R5 minute bit0", int'(rtc_out), 1);
        check_state("R5 R6 routing edges");

        // R3 R4 R10: load 23:59:59, bypass, one tick rolls everything
        do_write(3, 1);
        do_write(2, time_word(59, 59, 23));
        do_write(0, 17 | 32);
        do_tick();
        check_state("R3 R10 full rollover");
        check("R7 hour tap fall sets wake", int'(wake_o), 1);

        // R8: write of zero leaves flag, write of one clears it
        do_write(3, 0);
        check("R8 zero write ignored", int'(wake_o), 1);
        do_write(3, 1);
        check("R8 clear", int'(wake_o), 0);

        // R4: out-of-range fields load as zero
        do_write(2, time_word(63, 60, 24));
        check_state("R4 range clamp");

        // R9: switching to code 0 or 20 from a high tap stays quiet
        do_write(0, 0);
        do_write(2, time_word(1, 0, 0));
        do_write(0, 1);
        v = irq_seen;
        do_write(0, 0);
        check("R9 code zero no irq", irq_seen, v);
        do_write(0, 1);
        do_write(0, 20);
        check("R9 code 20 no irq", irq_seen, v);
        check("R9 no wake", int'(wake_o), 0);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 70) do_tick();
            else if (r < 80) do_write(0, int'($urandom_range(0, 31)) | ((($urandom_range(0, 3) == 0) ? 1 : 0) << 5));
            else if (r < 85) do_write(1, int'($urandom_range(0, 15)));
            else if (r < 93) do_write(2, time_word(int'($urandom_range(50, 63)),
                                                   int'($urandom_range(55, 61)),
                                                   int'($urandom_range(20, 25))));
            else do_write(3, int'($urandom_range(0, 1)));
            if (i % 25 == 24) check_state("R2 R3 R6 R7 R8 random");
        end

        // R11: readback of control and reload words
        do_write(0, 13 | 32);
        do_write(1, 9);
        do_read(0, v);
        check("R11 control read", v, 13 | 32);
        do_read(1, v);
        check("R11 reload read", v, 9);
        do_read(3, v);
        check("R11 status read", v, m_flag);

        done = 1;
        report();
        $finish;
    end
endmodule